// File: doc/BRIEF.md
# Vector register index remapping unit

This unit sits in the operand decode stage of a vector pipeline. It applies a relative register offset to chosen operands of each issued instruction. Two small configuration registers live inside it. The first is a control word, in which a single enable bit switches offsetting on. The second is an offset word, which holds an 8-bit offset and a 4-bit operand-select mask. Each register has its own write port.

Every issued instruction presents three 9-bit source operand codes and one 8-bit destination vector register number. When offsetting is enabled, each selected operand has the stored offset added to its vector register number. The result is checked against the number of vector registers currently available. A selected operand whose result falls outside that range, or that does not name a vector register in the first place, is replaced by vector register zero, and a per-operand flag records the substitution. The remapped operands leave through a register stage one cycle after they arrive.

Top module: `vrx_remap`

## Requirements
- R1: After reset both configuration registers read as zero (offsetting off, offset 0, mask 0), out_valid is 0, and all operand outputs and flags are 0.
- R2: When bit 27 of the control word is 0, every operand passes to the output unchanged and every substitution flag is 0, whatever the mask and offset hold.
- R3: The offset is taken from bits 7:0 of the offset word and the select mask from bits 15:12. All other bits of both words have no effect on the outputs.
- R4: Mask bit 0 selects source 0, bit 1 selects source 1, bit 2 selects source 2 and bit 3 selects the destination. An operand whose mask bit is 0 passes unchanged with its flag at 0.
- R5: Source codes 256 to 511 name vector registers 0 to 255. A selected source naming vector register n leaves as code 256 + n + offset when that sum is in range.
- R6: A selected destination d leaves as d + offset when that sum is in range.
- R7: The sum is formed at 9 bits. A sum that is greater than or equal to vgpr_count (1 to 256) makes the operand vector register 0 (source code 256, destination 0) and sets its flag.
- R8: A selected source with a code below 256 (not a vector register) leaves as code 256 with its flag set.
- R9: A configuration write takes effect for instructions issued on the cycle after the write. An instruction issued in the same cycle as the write uses the old value.
- R10: Outputs are registered with one cycle of latency. out_valid equals in_valid of the previous cycle, and the outputs hold while no instruction is issued.
- R11: The flag for an operand (out_zeroed bit 0/1/2 for the sources, bit 3 for the destination) is 1 exactly when that operand was substituted by vector register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Control word write enable |
| ctrl_wdata | input | 32 | Control word data; bit 27 enables offsetting |
| offs_we | input | 1 | Offset word write enable |
| offs_wdata | input | 32 | Offset word data; bits 7:0 offset, 15:12 mask |
| vgpr_count | input | 9 | Number of available vector registers, 1 to 256 |
| in_valid | input | 1 | An instruction is issued this cycle |
| src0_code | input | 9 | Source operand 0 code |
| src1_code | input | 9 | Source operand 1 code |
| src2_code | input | 9 | Source operand 2 code |
| dst_reg | input | 8 | Destination vector register number |
| out_valid | output | 1 | Remapped operands valid |
| out_src0 | output | 9 | Remapped source 0 code |
| out_src1 | output | 9 | Remapped source 1 code |
| out_src2 | output | 9 | Remapped source 2 code |
| out_dst | output | 8 | Remapped destination number |
| out_zeroed | output | 4 | Per-operand substitution flags |

## Verification
The bench aims at the 8-bit carry boundary. With 256 registers and offset 255, register 1 must become register 0 with its flag set. A design that keeps only 8 bits of the sum would instead wrap the result to register 0 with no flag, and a design that compares only to 255 would let the sum through. The bench also drives vgpr_count of 1 and sums that land exactly on the count, which exposes off-by-one comparisons. It drives scalar and constant source codes under a mask that selects them, which catches a design that offsets non-vector codes. A write issued in the same cycle as an instruction checks that a design does not apply new configuration one cycle early. Offset and control words with unrelated bits set, and masks that select single operands, catch wrong field positions and swapped mask bits.

// File: rtl/vrx_pkg.sv
package vrx_pkg;
  localparam int unsigned VREG_W  = 8;
  localparam int unsigned CODE_W  = VREG_W + 1;
  localparam int unsigned CNT_W   = VREG_W + 1;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned NLANE   = 4;
  localparam int unsigned EN_BIT  = 27;
  localparam int unsigned OFS_LO  = 0;
  localparam int unsigned MASK_LO = 12;

  typedef struct packed {
    logic              en;
    logic [NLANE-1:0]  mask;
    logic [VREG_W-1:0] ofs;
  } vrx_cfg_t;

  // A code names a vector register when its top bit is set.
  function automatic logic vrx_is_vec(input logic [CODE_W-1:0] code);
    return code[CODE_W-1];
  endfunction

  // Widened sum so a carry out of VREG_W bits remains visible.
  function automatic logic [CNT_W-1:0] vrx_sum(input logic [VREG_W-1:0] n,
                                               input logic [VREG_W-1:0] ofs);
    return {1'b0, n} + {1'b0, ofs};
  endfunction

  function automatic logic vrx_in_range(input logic [CNT_W-1:0] s,
                                        input logic [CNT_W-1:0] cnt);
    return s < cnt;
  endfunction
endpackage

// File: rtl/vrx_cfg_regs.sv
module vrx_cfg_regs
  import vrx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [WORD_W-1:0] ctrl_wdata,
  input  logic              offs_we,
  input  logic [WORD_W-1:0] offs_wdata,
  output vrx_cfg_t          cfg
);
  logic              en_q;
  logic [NLANE-1:0]  mask_q;
  logic [VREG_W-1:0] ofs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mask_q <= '0;
      ofs_q  <= '0;
    end else begin
      if (ctrl_we) en_q <= ctrl_wdata[EN_BIT];
      if (offs_we) begin
        mask_q <= offs_wdata[MASK_LO +: NLANE];
        ofs_q  <= offs_wdata[OFS_LO +: VREG_W];
      end
    end
  end

  assign cfg = '{en: en_q, mask: mask_q, ofs: ofs_q};

  // Bits outside the stored fields are deliberately dropped.
  logic unused_wbits;
  assign unused_wbits = ^{ctrl_wdata[WORD_W-1:EN_BIT+1], ctrl_wdata[EN_BIT-1:0],
                          offs_wdata[WORD_W-1:MASK_LO+NLANE],
                          offs_wdata[MASK_LO-1:OFS_LO+VREG_W]};

  p_ctrl_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> cfg.en == $past(ctrl_wdata[EN_BIT]));
  p_offs_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    offs_we |=> (cfg.ofs == $past(offs_wdata[7:0])) && (cfg.mask == $past(offs_wdata[15:12])));
  p_hold_cfg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_we && !offs_we && $past(rst_n)) |=> $stable(cfg));
endmodule

// File: rtl/vrx_lane_map.sv
module vrx_lane_map
  import vrx_pkg::*;
(
  input  logic              apply,
  input  logic [VREG_W-1:0] ofs,
  input  logic [CNT_W-1:0]  vgpr_count,
  input  logic [CODE_W-1:0] code_in,
  output logic [CODE_W-1:0] code_out,
  output logic              zeroed
);
  // Named internal events, visible to assertions and waveforms.
  logic              lane_is_vec;
  logic [CNT_W-1:0]  lane_sum;
  logic              lane_fits;
  logic              lane_sub;

  assign lane_is_vec = vrx_is_vec(code_in);
  assign lane_sum    = vrx_sum(code_in[VREG_W-1:0], ofs);
  assign lane_fits   = vrx_in_range(lane_sum, vgpr_count);
  assign lane_sub    = apply && !(lane_is_vec && lane_fits);

  always_comb begin
    if (!apply)        code_out = code_in;
    else if (lane_sub) code_out = {1'b1, {VREG_W{1'b0}}};
    else               code_out = {1'b1, lane_sum[VREG_W-1:0]};
  end
  assign zeroed = lane_sub;
endmodule

// File: rtl/vrx_remap.sv
module vrx_remap
  import vrx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_we,
  input  logic [31:0] ctrl_wdata,
  input  logic        offs_we,
  input  logic [31:0] offs_wdata,
  input  logic [8:0]  vgpr_count,
  input  logic        in_valid,
  input  logic [8:0]  src0_code,
  input  logic [8:0]  src1_code,
  input  logic [8:0]  src2_code,
  input  logic [7:0]  dst_reg,
  output logic        out_valid,
  output logic [8:0]  out_src0,
  output logic [8:0]  out_src1,
  output logic [8:0]  out_src2,
  output logic [7:0]  out_dst,
  output logic [3:0]  out_zeroed
);
  vrx_cfg_t cfg;

  vrx_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .offs_we(offs_we), .offs_wdata(offs_wdata),
    .cfg(cfg)
  );

  logic [CODE_W-1:0] lane_in  [NLANE];
  logic [CODE_W-1:0] lane_out [NLANE];
  logic [NLANE-1:0]  lane_zero;

  // The destination rides the same lane as a vector-register code.
  assign lane_in[0] = src0_code;
  assign lane_in[1] = src1_code;
  assign lane_in[2] = src2_code;
  assign lane_in[3] = {1'b1, dst_reg};

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    vrx_lane_map u_lane (
      .apply(cfg.en && cfg.mask[g]),
      .ofs(cfg.ofs),
      .vgpr_count(vgpr_count),
      .code_in(lane_in[g]),
      .code_out(lane_out[g]),
      .zeroed(lane_zero[g])
    );
  end

  logic dst_top_unused;
  assign dst_top_unused = lane_out[3][CODE_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_src0   <= '0;
      out_src1   <= '0;
      out_src2   <= '0;
      out_dst    <= '0;
      out_zeroed <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_src0   <= lane_out[0];
        out_src1   <= lane_out[1];
        out_src2   <= lane_out[2];
        out_dst    <= lane_out[3][VREG_W-1:0];
        out_zeroed <= lane_zero;
      end
    end
  end

  p_off_passes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cfg.en) |=> (out_src0 == $past(src0_code)) && (out_src1 == $past(src1_code))
      && (out_src2 == $past(src2_code)) && (out_dst == $past(dst_reg)) && (out_zeroed == 4'd0));
  p_unsel_dst_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cfg.mask[3]) |=> (out_dst == $past(dst_reg)) && !out_zeroed[3]);
  p_src_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cfg.en && cfg.mask[0] && !src0_code[8]) |=> (out_src0 == 9'd256) && out_zeroed[0]);
  p_flag_dst_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_zeroed[3]) |-> out_dst == 8'd0);
  p_flag_src1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_zeroed[1]) |-> out_src1 == 9'd256);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && $past(rst_n)) |=> $stable(out_src0) && $stable(out_dst) && $stable(out_zeroed));
endmodule

// File: tb/vrx_remap_tb.sv
module vrx_remap_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_we = 1'b0, offs_we = 1'b0, in_valid = 1'b0;
  logic [31:0] ctrl_wdata = '0, offs_wdata = '0;
  logic [8:0] vgpr_count = 9'd256;
  logic [8:0] src0_code = '0, src1_code = '0, src2_code = '0;
  logic [7:0] dst_reg = '0;
  logic out_valid;
  logic [8:0] out_src0, out_src1, out_src2;
  logic [7:0] out_dst;
  logic [3:0] out_zeroed;

  int checks = 0, errors = 0;
  bit m_en = 0; int m_ofs = 0; int m_mask = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vrx_remap u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .offs_we(offs_we), .offs_wdata(offs_wdata), .vgpr_count(vgpr_count),
    .in_valid(in_valid), .src0_code(src0_code), .src1_code(src1_code),
    .src2_code(src2_code), .dst_reg(dst_reg), .out_valid(out_valid),
    .out_src0(out_src0), .out_src1(out_src1), .out_src2(out_src2),
    .out_dst(out_dst), .out_zeroed(out_zeroed)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Behavioural model: source in integer register-space terms.
  function automatic int model_src(input int code, input bit pick, output bit z);
    int n;
    z = 0;
    if (!(m_en && pick)) return code;
    if (code < 256) begin z = 1; return 256; end
    n = (code - 256) + m_ofs;
    if (n >= int'(vgpr_count)) begin z = 1; return 256; end
    return 256 + n;
  endfunction

  function automatic int model_dst(input int d, output bit z);
    int n;
    z = 0;
    if (!(m_en && m_mask[3])) return d;
    n = d + m_ofs;
    if (n >= int'(vgpr_count)) begin z = 1; return 0; end
    return n;
  endfunction

  // One instruction slot: drive at negedge, check one cycle later.
  task automatic issue(input string req, input int s0, input int s1, input int s2, input int d,
                       input int cnt, input bit cwe = 0, input int cwd = 0,
                       input bit owe = 0, input int owd = 0);
    int e0, e1, e2, ed; bit z0, z1, z2, zd;
    in_valid = 1; src0_code = 9'(s0); src1_code = 9'(s1); src2_code = 9'(s2);
    dst_reg = 8'(d); vgpr_count = 9'(cnt);
    ctrl_we = cwe; ctrl_wdata = 32'(cwd); offs_we = owe; offs_wdata = 32'(owd);
    e0 = model_src(s0, m_mask[0], z0);
    e1 = model_src(s1, m_mask[1], z1);
    e2 = model_src(s2, m_mask[2], z2);
    ed = model_dst(d, zd);
    @(posedge clk);
    if (cwe) m_en = cwd[27];
    if (owe) begin m_ofs = owd & 255; m_mask = (owd >> 12) & 15; end
    @(negedge clk);
    in_valid = 0; ctrl_we = 0; offs_we = 0;
    chk(req, "valid", out_valid, 1);
    chk(req, "src0", out_src0, e0);
    chk(req, "src1", out_src1, e1);
    chk(req, "src2", out_src2, e2);
    chk(req, "dst", out_dst, ed);
    chk(req, "flags", out_zeroed, {zd, z2, z1, z0});
  endtask

  task automatic write_cfg(input bit cwe, input int cwd, input bit owe, input int owd);
    ctrl_we = cwe; ctrl_wdata = 32'(cwd); offs_we = owe; offs_wdata = 32'(owd);
    @(posedge clk);
    if (cwe) m_en = cwd[27];
    if (owe) begin m_ofs = owd & 255; m_mask = (owd >> 12) & 15; end
    @(negedge clk);
    ctrl_we = 0; offs_we = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "valid", out_valid, 0);
    chk("R1", "src0", out_src0, 0);
    chk("R1", "flags", out_zeroed, 0);
    rst_n = 1;
    @(negedge clk);
    // R1: reset config is off, so operands pass.
    issue("R1", 300, 5, 511, 200, 256);
    // R2: mask and offset loaded but enable bit clear.
    write_cfg(0, 0, 1, 32'h0000_F005);
    issue("R2", 256, 10, 400, 250, 16);
    // R9: enable written in the same cycle as an issue; old value applies.
    issue("R9", 260, 261, 262, 3, 256, 1, 32'h0800_0000);
    issue("R9", 260, 261, 262, 3, 256);
    // R5/R6: in-range sums on every operand.
    issue("R5", 256, 300, 356, 0, 256);
    issue("R6", 256, 256, 256, 100, 256);
    // R7: exact boundary and carry out of 8 bits.
    write_cfg(0, 0, 1, 32'h0000_F0FF);
    issue("R7", 257, 256, 511, 1, 256);
    write_cfg(0, 0, 1, 32'h0000_F000);
    issue("R7", 256, 257, 256, 0, 1);
    write_cfg(0, 0, 1, 32'h0000_F004);
    issue("R7", 267, 268, 256, 12, 16);
    // R8: scalar and constant codes selected.
    issue("R8", 0, 128, 255, 2, 64);
    // R4: single mask bits.
    for (int b = 0; b < 4; b++) begin
      write_cfg(0, 0, 1, (1 << (12 + b)) | 7);
      issue("R4", 5, 300, 300, 250, 200);
    end
    // R3: unrelated bits set in both words.
    write_cfg(1, 32'hF7FF_FFFF, 0, 0);
    issue("R3", 256, 0, 300, 0, 256);
    write_cfg(1, 32'h0800_0000, 1, 32'hFFFF_0F03);
    issue("R3", 256, 0, 300, 0, 256);
    // R10: outputs hold while idle.
    begin
      logic [8:0] h0; logic [7:0] hd; logic [3:0] hz;
      h0 = out_src0; hd = out_dst; hz = out_zeroed;
      repeat (3) @(negedge clk);
      chk("R10", "idle valid", out_valid, 0);
      chk("R10", "hold src0", out_src0, h0);
      chk("R10", "hold dst", out_dst, hd);
      chk("R10", "hold flags", out_zeroed, hz);
    end
    // R11: mixed pseudo-random traffic.
    for (int i = 0; i < 300; i++) begin
      if (i % 25 == 0)
        write_cfg(1, ($urandom % 2) << 27, 1, $urandom);
      issue("R11", $urandom % 512, $urandom % 512, $urandom % 512, $urandom % 256,
            1 + ($urandom % 256));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule